// File: doc/BRIEF.md
# Static Subset Barrier Synchronizer

This block holds a group of processors at barriers whose membership is fixed ahead of time. A separate producer loads barrier masks, one bit per processor, into an internal first-in first-out buffer well before they are needed. Only the oldest stored mask is live. Each processor signals arrival by holding its wait request high. When every member of the live mask is waiting, the block releases all of those members with a one-cycle pulse in the same clock cycle. It then retires the mask and moves on to the next one.

A processor that waits while it is not a member of the live mask stays pending. Its request is neither counted nor refused; it takes effect once a later mask that names it becomes live. Any subset of processors may form a barrier, from a single processor up to all of them. A mask with no bits set is discarded as soon as it becomes live.

Control is a three-state machine. `S_IDLE` means no mask is stored. `S_GATHER` means a mask is live and arrivals are being collected. `S_RELEASE` is the single recovery cycle in which the release pulse is driven. The transitions are:
- FILL: `S_IDLE` to `S_GATHER`, taken when a mask is stored.
- COMPLETE: `S_GATHER` to `S_RELEASE`, taken when all members are waiting; the mask is retired.
- SKIP: `S_GATHER` to `S_GATHER`, taken when the live mask is zero; the mask is retired with no pulse.
- DRAIN: `S_GATHER` to `S_IDLE`, taken when the buffer has become empty.
- RESUME: `S_RELEASE` to `S_GATHER`, taken when another mask is stored.
- REST: `S_RELEASE` to `S_IDLE`, taken when the buffer is empty.

Top module: `subset_barrier_sync`

## Requirements
- R1: A mask is stored on a clock edge where `mask_valid` and `mask_ready` are both high. `mask_ready` is low exactly when DEPTH (16) masks are stored, and a write offered while it is low is dropped.
- R2: Masks are used strictly in write order. Only the oldest stored mask can complete, even if the waits for a later mask are already all present.
- R3: When every set bit of the live mask has a counted wait at a clock edge (state `S_GATHER`), `release_pulse` equals that mask for exactly the next cycle. All members are released together and the mask is retired.
- R4: A wait from a processor whose bit is clear in the live mask produces no pulse for that processor. The wait stays pending and is counted when a later mask containing that processor becomes live.
- R5: While the buffer is empty, `release_pulse` stays zero whatever the wait requests are.
- R6: Wait requests are level-sensitive. After a processor is released, its request is not counted again until it has been seen low on at least one clock edge.
- R7: A mask of all zeros is retired at the first `S_GATHER` edge where it is live, and no pulse is issued for it.
- R8: Latency: for a mask written at edge t into an empty buffer, with all members already waiting, the pulse is visible after edge t+2. After a completion, the next mask is evaluated no earlier than the second edge after it.
- R9: After reset, `release_pulse` is zero and `mask_ready` is high.
- R10: A barrier with a single member (for example 8'h80) and a barrier with all members (8'hFF) each complete under the same rule as any other subset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_valid | input | 1 | Producer offers a barrier mask |
| mask_data | input | NPROC (8) | Barrier mask; bit i set means processor i takes part |
| mask_ready | output | 1 | Buffer has space for a mask |
| wait_req | input | NPROC (8) | Level wait request, one bit per processor |
| release_pulse | output | NPROC (8) | One-cycle release, one bit per processor |

## Verification
The bench targets four cases. The first is a non-member waiting ahead of its barrier: a design that counted that wait would release the processor early or complete the wrong mask. The second is a processor that holds its request across a release: a design without edge qualification would pass two consecutive barriers naming that processor on one wait. The bench also writes zero masks, single-member masks and all-member masks. A wrong design would hang on the zero mask or pulse for it. Finally, the bench fills the buffer and offers one extra mask: a design with wrong full accounting would accept it or lose one, and the count of drained pulses would then be off.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_GATHER  = 2'd1,
        S_RELEASE = 2'd2
    } sbs_state_e;

endpackage

// File: rtl/sbs_mask_queue.sv
module sbs_mask_queue #(
    parameter int NPROC = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [NPROC-1:0] wr_data,
    output logic             wr_ready,
    input  logic             pop,
    output logic             head_valid,
    output logic [NPROC-1:0] head_mask
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [NPROC-1:0] slots [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push, take;

    assign wr_ready   = (count != FULL);
    assign head_valid = (count != '0);
    assign head_mask  = slots[rd_ptr];
    assign push       = wr_valid && wr_ready;
    assign take       = pop && head_valid;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (take) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !take) begin
                count <= count + 1'b1;
            end else if (take && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    // R1: occupancy never exceeds the buffer depth
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    // R1: a write offered while full leaves the occupancy unchanged or lower
    a_r1_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL) |=> (count <= FULL) && !(count > $past(count)));

    // R2: retiring a mask only ever happens when one is stored
    a_r2_pop_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/sbs_arrival_track.sv
module sbs_arrival_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_in,
    input  logic fire,
    output logic armed
);
    logic spent;

    // once released, the level must fall before the request counts again
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spent <= 1'b0;
        end else begin
            spent <= (spent | fire) & wait_in;
        end
    end

    assign armed = wait_in & ~spent;

    // R6: a processor just released is not counted on the following edge
    a_r6_no_double_count: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed);
endmodule

// File: rtl/sbs_barrier_ctrl.sv
module sbs_barrier_ctrl
    import sbs_pkg::*;
#(
    parameter int NPROC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [NPROC-1:0] head_mask,
    input  logic [NPROC-1:0] armed,
    output logic             pop,
    output logic [NPROC-1:0] fire_vec,
    output logic [NPROC-1:0] release_pulse
);
    sbs_state_e state, state_nx;
    logic       all_in, is_zero, go;

    assign is_zero = (head_mask == '0);
    assign all_in  = ((armed & head_mask) == head_mask);

    always_comb begin
        state_nx = state;
        go       = 1'b0;
        pop      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (head_valid) state_nx = S_GATHER;        // FILL
            end
            S_GATHER: begin
                if (!head_valid) begin
                    state_nx = S_IDLE;                      // DRAIN
                end else if (is_zero) begin
                    pop      = 1'b1;                        // SKIP
                end else if (all_in) begin
                    pop      = 1'b1;                        // COMPLETE
                    go       = 1'b1;
                    state_nx = S_RELEASE;
                end
            end
            S_RELEASE: begin
                state_nx = head_valid ? S_GATHER : S_IDLE;  // RESUME / REST
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign fire_vec = go ? head_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            release_pulse <= '0;
        end else begin
            release_pulse <= fire_vec;
        end
    end

    // R3: a pulse lasts exactly one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (release_pulse != '0) |=> (release_pulse == '0));

    // R3: every pulsed processor was waiting on the edge that fired it
    a_r3_members_waited: assert property (@(posedge clk) disable iff (!rst_n)
        (release_pulse != '0) |-> ((release_pulse & ~$past(armed)) == '0));

    // R5: no pulse follows an edge where nothing was stored
    a_r5_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |=> (release_pulse == '0));

    // R7: retiring a zero mask never produces a pulse
    a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_zero) |=> (release_pulse == '0));

    // R8: a completion is always followed by the recovery state
    a_r8_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (release_pulse != '0) |-> (state == S_RELEASE));
endmodule

// File: rtl/subset_barrier_sync.sv
module subset_barrier_sync #(
    parameter int NPROC = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_valid,
    input  logic [NPROC-1:0] mask_data,
    output logic             mask_ready,
    input  logic [NPROC-1:0] wait_req,
    output logic [NPROC-1:0] release_pulse
);
    logic             head_valid, pop;
    logic [NPROC-1:0] head_mask, armed, fire_vec;

    sbs_mask_queue #(.NPROC(NPROC), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (mask_valid),
        .wr_data    (mask_data),
        .wr_ready   (mask_ready),
        .pop        (pop),
        .head_valid (head_valid),
        .head_mask  (head_mask)
    );

    for (genvar i = 0; i < NPROC; i++) begin : g_track
        sbs_arrival_track u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .wait_in (wait_req[i]),
            .fire    (fire_vec[i]),
            .armed   (armed[i])
        );
    end

    sbs_barrier_ctrl #(.NPROC(NPROC)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid    (head_valid),
        .head_mask     (head_mask),
        .armed         (armed),
        .pop           (pop),
        .fire_vec      (fire_vec),
        .release_pulse (release_pulse)
    );

    // R4: a processor pulses only if it was requesting on the previous edge
    a_r4_only_waiters: assert property (@(posedge clk) disable iff (!rst_n)
        ((release_pulse & ~$past(wait_req)) == '0));
endmodule

// File: tb/subset_barrier_sync_test.sv
module subset_barrier_sync_test;
    localparam int NP = 8;
    localparam int DP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_valid = 1'b0;
    logic [NP-1:0] mask_data = '0;
    logic          mask_ready;
    logic [NP-1:0] wait_req = '0;
    logic [NP-1:0] release_pulse;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // bench-side processor behaviour
    logic [NP-1:0] eager = '0;   // re-raise wait a cycle after dropping
    logic [NP-1:0] hold  = '0;   // keep wait high through release
    int            pulses [NP];

    // reference model state
    logic [NP-1:0] mq [$];
    int            m_st = 0;     // 0 idle, 1 gather, 2 release
    logic [NP-1:0] m_spent = '0;
    logic [NP-1:0] m_rel = '0;

    always #10 clk = ~clk;

    subset_barrier_sync #(.NPROC(NP), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .mask_valid(mask_valid), .mask_data(mask_data),
        .mask_ready(mask_ready), .wait_req(wait_req), .release_pulse(release_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model: update on each rising edge using the values seen before it
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_st = 0; m_spent = '0; m_rel = '0;
        end else begin
            logic [NP-1:0] fire;
            logic [NP-1:0] eff;
            bit            hv;
            bit            rdy;
            bit            popq;
            hv   = (mq.size() > 0);
            rdy  = (mq.size() < DP);
            eff  = wait_req & ~m_spent;
            fire = '0;
            popq = 0;
            case (m_st)
                0: if (hv) m_st = 1;
                1: begin
                    if (!hv) m_st = 0;
                    else if (mq[0] == '0) popq = 1;
                    else if ((eff & mq[0]) == mq[0]) begin
                        fire = mq[0]; popq = 1; m_st = 2;
                    end
                end
                default: m_st = hv ? 1 : 0;
            endcase
            if (popq) void'(mq.pop_front());
            if (mask_valid && rdy) mq.push_back(mask_data);
            m_rel   = fire;
            m_spent = (m_spent | fire) & wait_req;
        end
    end

    // compare, count pulses and act as processors on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            check(release_pulse == m_rel, "R3 model release", int'(release_pulse), int'(m_rel));
            check(mask_ready == (mq.size() < DP), "R1 model ready", int'(mask_ready), int'(mq.size() < DP));
            for (int i = 0; i < NP; i++) begin
                if (release_pulse[i]) begin
                    pulses[i]++;
                    if (!hold[i]) wait_req[i] = 1'b0;
                end else if (eager[i] && !wait_req[i]) begin
                    wait_req[i] = 1'b1;
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [NP-1:0] m);
        @(negedge clk);
        while (!mask_ready) @(negedge clk);
        mask_valid = 1'b1; mask_data = m;
        @(negedge clk);
        mask_valid = 1'b0;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NP; i++) pulses[i] = 0;
    endtask

    initial begin
        clear_counts();
        repeat (3) @(negedge clk);
        check(release_pulse == '0, "R9 reset release", int'(release_pulse), 0);
        check(mask_ready == 1'b1, "R9 reset ready", int'(mask_ready), 1);
        rst_n = 1'b1;

        // R5: empty buffer, everybody waits
        wait_req = '1;
        idle(6);
        check(pulses[0] + pulses[7] == 0, "R5 empty no release", pulses[0] + pulses[7], 0);
        wait_req = '0;
        idle(2);

        // R4 / R2: non-members 2,3 wait first; head is 8'h03
        push(8'h03); push(8'h0C); push(8'h00); push(8'h80); push(8'hFF);
        wait_req[3:2] = 2'b11;
        idle(6);
        check(pulses[2] == 0, "R4 non-member held", pulses[2], 0);
        check(pulses[3] == 0, "R2 later mask waits for head", pulses[3], 0);
        wait_req[1:0] = 2'b11;
        idle(8);
        check(pulses[0] == 1 && pulses[1] == 1, "R3 head members released", pulses[0], 1);
        check(pulses[2] == 1 && pulses[3] == 1, "R4 pending wait counted later", pulses[2], 1);
        // R7 zero mask skipped; R10 single member
        wait_req[7] = 1'b1;
        idle(6);
        check(pulses[7] == 1, "R10 single member 80", pulses[7], 1);
        check(pulses[4] == 0, "R7 zero mask no pulse", pulses[4], 0);
        wait_req = '1;
        idle(6);
        for (int i = 0; i < NP; i++)
            check(pulses[i] == ((i < 4) ? 2 : (i == 7 ? 2 : 1)), "R10 all-member barrier", pulses[i], 0);
        wait_req = '0;
        idle(3);

        // R6: processor 0 holds its request through a release
        clear_counts();
        hold[0] = 1'b1;
        push(8'h01); push(8'h01);
        wait_req[0] = 1'b1;
        idle(10);
        check(pulses[0] == 1, "R6 held level counted once", pulses[0], 1);
        wait_req[0] = 1'b0;
        idle(1);
        wait_req[0] = 1'b1;
        idle(6);
        check(pulses[0] == 2, "R6 counted after drop", pulses[0], 2);
        hold[0] = 1'b0;
        wait_req = '0;
        idle(3);

        // R8: latency from write into an empty buffer
        wait_req[5] = 1'b1;
        @(negedge clk);
        mask_valid = 1'b1; mask_data = 8'h20;
        @(negedge clk);               // after write edge t
        mask_valid = 1'b0;
        check(release_pulse == '0, "R8 no pulse after t", int'(release_pulse), 0);
        @(negedge clk);               // after t+1
        check(release_pulse == '0, "R8 no pulse after t+1", int'(release_pulse), 0);
        @(negedge clk);               // after t+2
        check(release_pulse == 8'h20, "R8 pulse after t+2", int'(release_pulse), 32'h20);
        idle(3);

        // R1: fill the buffer, offer one extra, then drain
        clear_counts();
        for (int k = 0; k < DP; k++) push(8'h10);
        check(mask_ready == 1'b0, "R1 ready low when full", int'(mask_ready), 0);
        @(negedge clk);
        mask_valid = 1'b1; mask_data = 8'h10;
        @(negedge clk);
        mask_valid = 1'b0;
        eager[4] = 1'b1;
        idle(80);
        check(pulses[4] == DP, "R1 extra write dropped", pulses[4], DP);
        check(mask_ready == 1'b1, "R1 ready after drain", int'(mask_ready), 1);
        eager = '0;
        wait_req = '0;
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule